// File: doc/BRIEF.md
# Circular Pending-Event Slot Search

This unit locates the next processor slot that has any outstanding hot-plug event. A controller pulses `start` when it decodes its next-event command, presenting the current selector value, the number of populated slots, and three per-slot pending vectors: insertion pending, removal pending, and firmware-removal pending. The unit walks the slots one per clock. The walk begins with the selected slot itself, wraps from the last populated slot back to slot 0, and gives up after one full lap.

When a pending slot is found, the unit reports its index as the new selector value. When no slot is pending, it hands back the starting selector unchanged. A busy flag and a one-cycle done pulse let the surrounding register logic stall reads of the selector until the walk has finished. Decoding of the register interface and storage of the event flags belong to the surrounding controller.

Top module: `pend_slot_search`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `found` are 0 and `sel_out` is 0.
- R2: Bit i of each pending vector belongs to slot i. A slot counts as pending when its insert bit, its remove bit or its firmware-remove bit is 1, and any single one of these three suffices.
- R3: The slot named by `sel_in` is examined first. If that slot is pending, `done` is high during the second cycle after the cycle in which `start` was sampled, with `found`=1 and `sel_out`=`sel_in`.
- R4: Slots are examined in increasing order. After slot `slot_cnt`-1 the walk continues at slot 0. Slots at or above `slot_cnt` are never examined, even if their pending bits are set. A match at forward distance d from the selector raises `done` d+2 cycles after the start cycle.
- R5: If no slot in range is pending, the walk stops when the index would return to the starting selector. `done` then rises `slot_cnt`+1 cycles after the start cycle, with `found`=0 and `sel_out` equal to the starting selector.
- R6: `busy` is high from the cycle after an accepted in-range start until the search completes, and is low in the cycle where `done` is high. `done` is a single-cycle pulse.
- R7: A `start` pulse while `busy` is high is ignored: the running search keeps its original selector and slot count.
- R8: A start whose selector is not below `slot_cnt` (including `slot_cnt`=0) completes on the next cycle with `found`=0 and `sel_out`=`sel_in`, and `busy` never rises.
- R9: `sel_out` and `found` hold their last result until the next search completes, and `done` stays low in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Search request pulse |
| sel_in | input | SEL_W | Current selector, first slot to examine |
| slot_cnt | input | CNT_W | Number of populated slots |
| ins_pend | input | SLOTS | Per-slot insertion pending bits |
| rem_pend | input | SLOTS | Per-slot removal pending bits |
| fwr_pend | input | SLOTS | Per-slot firmware-removal pending bits |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Last search found a pending slot |
| sel_out | output | SEL_W | Resulting selector value |

## Verification
The bench builds the unit with SLOTS=6, SEL_W=4 and CNT_W=3. This configuration is small enough to sweep every slot count from 1 to 6, every in-range starting selector, and all 64 combined pending patterns, with the pending source rotated across the three vectors. That sweep reaches every match distance, every wrap point and every empty lap. It also reaches pending bits above the populated count, which must be skipped. With a 4-bit selector, out-of-range selectors up to 15 and a zero slot count can also be driven. Separate directed cases cover a start pulse issued while busy and the holding of results between searches.

// File: rtl/pend_search_pkg.sv
package pend_search_pkg;
  typedef enum logic [0:0] {
    SRCH_IDLE = 1'b0,
    SRCH_SCAN = 1'b1
  } srch_state_e;
endpackage

// File: rtl/pend_merge.sv
module pend_merge #(
  parameter int SLOTS = 8
) (
  input  logic [SLOTS-1:0] ins_pend,
  input  logic [SLOTS-1:0] rem_pend,
  input  logic [SLOTS-1:0] fwr_pend,
  output logic [SLOTS-1:0] any_pend
);
  // R2: a slot is pending if any of its three event bits is set
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign any_pend[g] = ins_pend[g] | rem_pend[g] | fwr_pend[g];
  end
endmodule

// File: rtl/slot_wrap_next.sv
module slot_wrap_next #(
  parameter int SLOTS = 8,
  parameter int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic [$clog2(SLOTS)-1:0] cur_idx,
  input  logic [CNT_W-1:0]         cnt,
  output logic [$clog2(SLOTS)-1:0] nxt_idx
);
  localparam int IDX_W = $clog2(SLOTS);
  logic [CNT_W-1:0] inc;

  always_comb begin
    inc = CNT_W'(cur_idx) + CNT_W'(1);
    // R4: wrap after the last populated slot
    if (inc >= cnt) nxt_idx = '0;
    else            nxt_idx = inc[IDX_W-1:0];
  end
endmodule

// File: rtl/pend_search_ctrl.sv
module pend_search_ctrl
  import pend_search_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int SEL_W = 8,
  parameter int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [SEL_W-1:0]         sel_in,
  input  logic [CNT_W-1:0]         slot_cnt,
  input  logic                     hit,
  input  logic [$clog2(SLOTS)-1:0] nxt_idx,
  output logic [$clog2(SLOTS)-1:0] idx_q,
  output logic [CNT_W-1:0]         cnt_q,
  output logic                     busy,
  output logic                     done,
  output logic                     found,
  output logic [SEL_W-1:0]         sel_out
);
  localparam int IDX_W = $clog2(SLOTS);
  localparam int CMP_W = (SEL_W > CNT_W) ? SEL_W : CNT_W;

  srch_state_e      state_q;
  logic [IDX_W-1:0] base_q;
  logic [CNT_W-1:0] cnt_eff;
  logic             out_range;

  always_comb begin
    cnt_eff   = (slot_cnt > CNT_W'(SLOTS)) ? CNT_W'(SLOTS) : slot_cnt;
    out_range = CMP_W'(sel_in) >= CMP_W'(cnt_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SRCH_IDLE;
      idx_q   <= '0;
      base_q  <= '0;
      cnt_q   <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      found   <= 1'b0;
      sel_out <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        SRCH_IDLE: begin
          if (start) begin
            if (out_range) begin
              done    <= 1'b1;
              found   <= 1'b0;
              sel_out <= sel_in;
            end else begin
              state_q <= SRCH_SCAN;
              busy    <= 1'b1;
              idx_q   <= sel_in[IDX_W-1:0];
              base_q  <= sel_in[IDX_W-1:0];
              cnt_q   <= cnt_eff;
            end
          end
        end
        SRCH_SCAN: begin
          if (hit) begin
            state_q <= SRCH_IDLE;
            busy    <= 1'b0;
            done    <= 1'b1;
            found   <= 1'b1;
            sel_out <= SEL_W'(idx_q);
          end else if (nxt_idx == base_q) begin
            state_q <= SRCH_IDLE;
            busy    <= 1'b0;
            done    <= 1'b1;
            found   <= 1'b0;
            sel_out <= SEL_W'(base_q);
          end else begin
            idx_q <= nxt_idx;
          end
        end
        default: state_q <= SRCH_IDLE;
      endcase
    end
  end

  assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_busy_from_start_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  assert_idx_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (CNT_W'(idx_q) < cnt_q));
  assert_miss_keeps_sel_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && !hit && nxt_idx == base_q) |=> (done && !found && sel_out == SEL_W'($past(base_q))));
  assert_out_range_R8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && out_range) |=> (done && !found && !busy));
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(rst)) |-> ($stable(sel_out) && $stable(found)));
endmodule

// File: rtl/pend_slot_search.sv
module pend_slot_search #(
  parameter int SLOTS = 8,
  parameter int SEL_W = 8,
  parameter int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [SEL_W-1:0] sel_in,
  input  logic [CNT_W-1:0] slot_cnt,
  input  logic [SLOTS-1:0] ins_pend,
  input  logic [SLOTS-1:0] rem_pend,
  input  logic [SLOTS-1:0] fwr_pend,
  output logic             busy,
  output logic             done,
  output logic             found,
  output logic [SEL_W-1:0] sel_out
);
  localparam int IDX_W = $clog2(SLOTS);

  logic [SLOTS-1:0] any_pend;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] nxt_idx;
  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  pend_merge #(.SLOTS(SLOTS)) u_merge (
    .ins_pend(ins_pend),
    .rem_pend(rem_pend),
    .fwr_pend(fwr_pend),
    .any_pend(any_pend)
  );

  assign hit = any_pend[idx_q];

  slot_wrap_next #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_wrap (
    .cur_idx(idx_q),
    .cnt    (cnt_q),
    .nxt_idx(nxt_idx)
  );

  pend_search_ctrl #(.SLOTS(SLOTS), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .sel_in  (sel_in),
    .slot_cnt(slot_cnt),
    .hit     (hit),
    .nxt_idx (nxt_idx),
    .idx_q   (idx_q),
    .cnt_q   (cnt_q),
    .busy    (busy),
    .done    (done),
    .found   (found),
    .sel_out (sel_out)
  );

  assert_reset_R1: assert property (@(posedge clk) rst |=> (!busy && !done && !found && sel_out == '0));
  assert_hit_reports_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && hit) |=> (done && found));
endmodule

// File: tb/pend_slot_search_tb.sv
module pend_slot_search_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 6;

  logic       clk = 1'b0;
  logic       rst;
  logic       start;
  logic [3:0] sel_in;
  logic [2:0] slot_cnt;
  logic [NS-1:0] ins_pend, rem_pend, fwr_pend;
  logic       busy, done, found;
  logic [3:0] sel_out;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pend_slot_search #(.SLOTS(NS), .SEL_W(4), .CNT_W(3)) u_dut (
    .clk(clk), .rst(rst), .start(start), .sel_in(sel_in), .slot_cnt(slot_cnt),
    .ins_pend(ins_pend), .rem_pend(rem_pend), .fwr_pend(fwr_pend),
    .busy(busy), .done(done), .found(found), .sel_out(sel_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  // Issues one search and checks latency, result and busy behaviour.
  task automatic run_search(input int cnt, input int sel, input logic [NS-1:0] pat,
                            input int rot, input string tag);
    int  exp_lat, exp_sel, cycles, busy_bad, k, i;
    bit  exp_found;
    exp_found = 0; exp_sel = sel; exp_lat = 1;
    if (sel < cnt) begin
      exp_lat = cnt + 1;
      for (k = 0; k < cnt; k++) begin
        i = (sel + k) % cnt;
        if (pat[i]) begin
          exp_found = 1; exp_sel = i; exp_lat = k + 2;
          break;
        end
      end
    end
    for (int b = 0; b < NS; b++) begin
      ins_pend[b] = pat[b] && ((b + rot) % 3 == 0);
      rem_pend[b] = pat[b] && ((b + rot) % 3 == 1);
      fwr_pend[b] = pat[b] && ((b + rot) % 3 == 2);
    end
    sel_in = 4'(sel); slot_cnt = 3'(cnt); start = 1'b1;
    cycles = 0; busy_bad = 0;
    while (cycles < 40) begin
      @(negedge clk);
      start = 1'b0;
      cycles++;
      if (done) break;
      if (!busy) busy_bad++;
    end
    chk(cycles == exp_lat, {tag, " latency"}, cycles, exp_lat);
    chk(found == exp_found, {tag, " found"}, int'(found), int'(exp_found));
    chk(int'(sel_out) == exp_sel, {tag, " sel_out"}, int'(sel_out), exp_sel);
    chk(busy_bad == 0 && !busy, "R6 busy during search", busy_bad, 0);
  endtask

  initial begin
    string tag;
    int    first;
    rst = 1'b1; start = 1'b0; sel_in = '0; slot_cnt = '0;
    ins_pend = '0; rem_pend = '0; fwr_pend = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset values
    chk(!busy && !done && !found && sel_out == 4'd0, "R1 reset state",
        int'({busy, done, found}), 0);

    // Exhaustive sweep over count, selector, pattern and source rotation
    for (int cnt = 1; cnt <= NS; cnt++)
      for (int sel = 0; sel < cnt; sel++)
        for (int p = 0; p < 64; p++)
          for (int rot = 0; rot < 3; rot++) begin
            first = -1;
            for (int k = 0; k < cnt; k++)
              if (first < 0 && p[(sel + k) % cnt]) first = (sel + k) % cnt;
            if (first < 0)        tag = "R5";
            else if (first == sel) tag = "R3";
            else if (first < sel)  tag = "R4";
            else                   tag = "R2";
            run_search(cnt, sel, 6'(p), rot, tag);
          end

    // R8: out-of-range selectors, including zero slot count
    for (int cnt = 0; cnt <= NS; cnt++)
      for (int sel = cnt; sel < 16; sel += 3)
        run_search(cnt, sel, 6'h3F, 0, "R8");

    // R7: start while busy is ignored
    ins_pend = '0; rem_pend = '0; fwr_pend = '0;
    sel_in = 4'd0; slot_cnt = 3'd6; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    sel_in = 4'd3; slot_cnt = 3'd2; start = 1'b1;
    @(negedge clk); start = 1'b0;
    begin
      int c;
      c = 3;
      while (!done && c < 40) begin @(negedge clk); c++; end
      chk(c == 7, "R7 ignored start latency", c, 7);
      chk(!found && sel_out == 4'd0, "R7 ignored start result", int'(sel_out), 0);
    end

    // R9: result holds between searches
    run_search(5, 2, 6'b000010, 1, "R4");
    repeat (3) @(negedge clk);
    chk(sel_out == 4'd1 && found && !done, "R9 hold", int'(sel_out), 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule